// File: doc/BRIEF.md
# Serial Command and Fault Frame Slave

This block is the host-facing serial port of an eight-channel output driver. A host, acting as a mode-0 SPI master, selects the slave, clocks in a command frame and, in the same transfer, clocks out a fault frame. A static mode input chooses between a short frame carrying only the eight channel bits and a long frame that adds status bits and a parity code protecting both directions. When the select line is released, the block checks the frame. If the frame is accepted, the channel-enable register is loaded. If it is rejected, the register keeps its value and an error flag is raised.

The serial clock and select inputs are brought into a faster system clock through synchronisers and turned into single-cycle events, so all state lives in one clock domain. Per-channel overtemperature events are held in a sticky latch until the transfer that reports them completes. Bits clocked in beyond the frame length travel on through the shift register and reappear on the serial output after the fault bits. This lets several slaves share one select line in a chain.

Top module: `spi_cmd_fault_slave`

## Requirements
- R1: After reset, `chan_en` is 0, `frame_err` is 0 and `sdo_oe` is 0.
- R2: `sdo_oe` is 0 while the slave is deselected. After selection, `sdo` shows the most significant reply bit. `sdi` is taken on each rising `sclk` edge, and `sdo` advances to the next reply bit, most significant first, only on falling `sclk` edges.
- R3: With `mode16`=0, an accepted transfer loads `chan_en` from the last 8 bits clocked in, with the last bit controlling channel 0. The reply is the 8 latched overtemperature bits, channel 7 first.
- R4: With `mode16`=1, the last 16 bits are {C7..C0, four ignored bits, Q2, Q1, Q0, nQ0}. They pass only if Q0 = XOR of C0..C7, Q1 = C1^C3^C5^C7, Q2 = C0^C2^C4^C6 and nQ0 = !Q0. The ignored bits have no effect.
- R5: With `mode16`=1, the reply is {T7..T0, fb_ok, temp_warn, PE, pwr_good, Q2, Q1, Q0, nQ0}, most significant bit first. Here Q0 = XOR of T0..T7, Q1 = PE^fb_ok^T1^T3^T5^T7, Q2 = pwr_good^temp_warn^T0^T2^T4^T6 and nQ0 = !Q0.
- R6: When the number of rising `sclk` edges in a transfer is not a multiple of 8, the frame is rejected: `frame_err` goes to 1 and `chan_en` is unchanged.
- R7: In 16-bit mode, a parity failure rejects the frame in the same way. An accepted frame clears `frame_err`.
- R8: The PE bit of a 16-bit reply equals `frame_err` as it stood when the transfer began.
- R9: An overtemperature flag sets its latch bit. The reply shows the latch as it was at the select edge, so later events are held for the next transfer. At deselection each latch bit is reloaded from its current flag.
- R10: Bits clocked in before the last 8 (or 16) appear on `sdo` right after the reply bits, in the order they were sent.
- R11: `chan_en` and `frame_err` change only in response to a deselect edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sclk |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data from the host |
| mode16 | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames; static |
| ovt_flags | input | 8 | Per-channel overtemperature flags |
| fb_ok | input | 1 | Regulator feedback good status |
| temp_warn | input | 1 | Case temperature warning status |
| pwr_good | input | 1 | Supply power good status |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| chan_en | output | 8 | Channel-enable register |
| frame_err | output | 1 | Last frame rejected |

## Verification
The bench builds the block with its default two-stage synchroniser and the fixed eight-channel frame. With this small configuration, every one of the 256 channel patterns can be swept in both frame modes. Each sweep includes full reply comparison, with overtemperature patterns and status bits changing every transfer. Beyond the sweeps, the bench corrupts each parity bit in turn and sends frames of wrong length. It also covers late overtemperature events, the ignored bits, and chained transfers of double length in each mode.

// File: rtl/spi_slave_pkg.sv
// Package: frame geometry and the parity functions shared by the slave.
// Assumes the fixed eight-channel frame; the long frame is two bytes.
package spi_slave_pkg;
    localparam int CH_N   = 8;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    // True when a 16-bit command word carries a consistent parity code.
    function automatic logic cmd_code_ok(input logic [WORD_W-1:0] w);
        logic [CH_N-1:0] c;
        logic q0, q1, q2;
        c  = w[WORD_W-1 -: CH_N];
        q0 = ^c;
        q1 = c[1] ^ c[3] ^ c[5] ^ c[7];
        q2 = c[0] ^ c[2] ^ c[4] ^ c[6];
        return (w[3] == q2) && (w[2] == q1) && (w[1] == q0) && (w[0] == !q0);
    endfunction

    // Builds the 16-bit reply word with its parity code.
    function automatic logic [WORD_W-1:0] reply_word(
        input logic [CH_N-1:0] t,
        input logic fb, input logic tw, input logic pe, input logic pg);
        logic q0, q1, q2;
        q0 = ^t;
        q1 = pe ^ fb ^ t[1] ^ t[3] ^ t[5] ^ t[7];
        q2 = pg ^ tw ^ t[0] ^ t[2] ^ t[4] ^ t[6];
        return {t, fb, tw, pe, pg, q2, q1, q0, !q0};
    endfunction
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchroniser with edge detection for a bundle of asynchronous
// inputs. Assumes each input stays stable for several system clocks.
module spi_in_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stage s of the metastability chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_V;
                else        chain[s] <= (s == 0) ? din : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_V;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_ovt_latch.sv
// Sticky per-channel overtemperature latch. Bits set on any active flag and
// are reloaded from the live flags when a transfer completes.
module spi_ovt_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic         done,
    output logic [N-1:0] held
);
    // Accumulate events; restart from the present flags at transfer end.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (done) held <= flags;
        else           held <= held | flags;
    end
endmodule

// File: rtl/spi_shift_core.sv
// Shared in/out shift register. Captures sdi on clock rises, shifts on
// clock falls, loads the reply at selection, counts rises modulo a byte.
// Assumes the host ends each transfer with sclk low.
module spi_shift_core
    import spi_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode16,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              ss_fall,
    input  logic              sdi_lvl,
    input  logic [WORD_W-1:0] load_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] shift_word,
    output logic [CNT_W-1:0]  edge_cnt
);
    logic cap;

    // Sample the data line and count edges on each clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap      <= 1'b0;
            edge_cnt <= '0;
        end else if (ss_fall) begin
            edge_cnt <= '0;
        end else if (sel && sclk_rise) begin
            cap      <= sdi_lvl;
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // Load the reply at selection, then move one bit per clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                 shift_word <= '0;
        else if (ss_fall)           shift_word <= load_word;
        else if (sel && sclk_fall)  shift_word <= {shift_word[WORD_W-2:0], cap};
    end

    // Output enable follows selection, aligned with the reply load.
    always_ff @(posedge clk) begin
        if (!rst_n) sdo_oe <= 1'b0;
        else        sdo_oe <= sel;
    end

    assign sdo = mode16 ? shift_word[WORD_W-1] : shift_word[BYTE_W-1];
endmodule

// File: rtl/spi_cmd_fault_slave.sv
// Serial command/fault slave for an eight-channel driver. Synchronises the
// serial pins, runs the shift core, and judges the frame at deselection.
// Assumes mode16 is static during a transfer.
module spi_cmd_fault_slave
    import spi_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            ss_n,
    input  logic            sdi,
    input  logic            mode16,
    input  logic [CH_N-1:0] ovt_flags,
    input  logic            fb_ok,
    input  logic            temp_warn,
    input  logic            pwr_good,
    output logic            sdo,
    output logic            sdo_oe,
    output logic [CH_N-1:0] chan_en,
    output logic            frame_err
);
    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic sclk_rise, sclk_fall, ss_rise, ss_fall, sel, sdi_lvl;
    logic [CH_N-1:0]   ovt_held;
    logic [WORD_W-1:0] load_word, shift_word;
    logic [CNT_W-1:0]  edge_cnt;
    logic              accept;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sdi, ss_n, sclk}),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    assign sclk_rise = pin_rise[0];
    assign sclk_fall = pin_fall[0];
    assign ss_rise   = pin_rise[1];
    assign ss_fall   = pin_fall[1];
    assign sel       = ~pin_lvl[1];
    assign sdi_lvl   = pin_lvl[2];

    spi_ovt_latch #(.N(CH_N)) u_ovt (
        .clk(clk), .rst_n(rst_n), .flags(ovt_flags), .done(ss_rise), .held(ovt_held)
    );

    // Reply word chosen by frame mode.
    always_comb begin
        if (mode16) load_word = reply_word(ovt_held, fb_ok, temp_warn, frame_err, pwr_good);
        else        load_word = {{(WORD_W-CH_N){1'b0}}, ovt_held};
    end

    spi_shift_core u_core (
        .clk(clk), .rst_n(rst_n), .mode16(mode16), .sel(sel),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ss_fall(ss_fall),
        .sdi_lvl(sdi_lvl), .load_word(load_word), .sdo(sdo), .sdo_oe(sdo_oe),
        .shift_word(shift_word), .edge_cnt(edge_cnt)
    );

    // Frame passes on whole bytes and, in long mode, a good parity code.
    assign accept = (edge_cnt == '0) && (!mode16 || cmd_code_ok(shift_word));

    // Judge the frame at deselection and update the visible registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_en   <= '0;
            frame_err <= 1'b0;
        end else if (ss_rise) begin
            frame_err <= !accept;
            if (accept)
                chan_en <= mode16 ? shift_word[WORD_W-1 -: CH_N] : shift_word[CH_N-1:0];
        end
    end
endmodule

// File: rtl/spi_cmd_fault_chk.sv
// Checker for spi_cmd_fault_slave: protocol and register-update properties.
module spi_cmd_fault_chk
    import spi_slave_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ss_rise,
    input logic            ss_fall,
    input logic            sclk_fall,
    input logic            sdo,
    input logic            sdo_oe,
    input logic [CH_N-1:0] chan_en,
    input logic            frame_err,
    input logic [CH_N-1:0] ovt_flags,
    input logic [CH_N-1:0] ovt_held
);
    assert_chan_on_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en != $past(chan_en)) |-> $past(ss_rise));

    assert_err_on_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err != $past(frame_err)) |-> $past(ss_rise));

    assert_load_only_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en != $past(chan_en)) |-> !frame_err);

    assert_oe_off_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_rise |=> !sdo_oe);

    assert_oe_on_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> sdo_oe);

    assert_sdo_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> $past(sclk_fall || ss_fall));

    assert_ovt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovt_flags != '0) |=> ((ovt_held & $past(ovt_flags)) == $past(ovt_flags)));
endmodule

bind spi_cmd_fault_slave spi_cmd_fault_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ss_rise(ss_rise), .ss_fall(ss_fall),
    .sclk_fall(sclk_fall), .sdo(sdo), .sdo_oe(sdo_oe), .chan_en(chan_en),
    .frame_err(frame_err), .ovt_flags(ovt_flags), .ovt_held(ovt_held)
);

// File: tb/tb_spi_cmd_fault_slave.sv
// Bench: sweeps every channel pattern in both modes, plus error and chain cases.
module tb_spi_cmd_fault_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, ss_n = 1'b1, sdi = 1'b0, mode16 = 1'b0;
    logic [7:0] ovt_flags = '0;
    logic fb_ok = 1'b0, temp_warn = 1'b0, pwr_good = 1'b0;
    logic sdo, sdo_oe, frame_err;
    logic [7:0] chan_en;

    int checks = 0, errors = 0;
    logic [7:0] exp_lat = '0;
    logic [7:0] exp_chan = '0;
    logic       exp_err = 1'b0;
    logic [7:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_fault_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .sdi(sdi),
        .mode16(mode16), .ovt_flags(ovt_flags), .fb_ok(fb_ok),
        .temp_warn(temp_warn), .pwr_good(pwr_good), .sdo(sdo),
        .sdo_oe(sdo_oe), .chan_en(chan_en), .frame_err(frame_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk_cmd(input logic [7:0] c, input logic [3:0] dc);
        logic q0 = ^c;
        logic q1 = c[1] ^ c[3] ^ c[5] ^ c[7];
        logic q2 = c[0] ^ c[2] ^ c[4] ^ c[6];
        return {c, dc, q2, q1, q0, ~q0};
    endfunction

    function automatic logic code_ok(input logic [15:0] w);
        return w == mk_cmd(w[15:8], w[7:4]);
    endfunction

    function automatic logic [15:0] mk_reply(input logic [7:0] t, input logic fb,
                                             input logic tw, input logic pe, input logic pg);
        logic q0 = ^t;
        logic q1 = pe ^ fb ^ (t[1] ^ t[3] ^ t[5] ^ t[7]);
        logic q2 = pg ^ tw ^ (t[0] ^ t[2] ^ t[4] ^ t[6]);
        return {t, fb, tw, pe, pg, q2, q1, q0, ~q0};
    endfunction

    // Sets the live flags while deselected and updates the latch model.
    task automatic set_flags(input logic [7:0] p);
        ovt_flags = p;
        exp_lat   = exp_lat | p;
        idle(2);
    endtask

    // One transfer of nbits, most significant first; optional late flag change.
    task automatic xfer(input int nbits, input logic [31:0] din, input bit late_en,
                        input logic [7:0] late, output logic [31:0] dout);
        dout = '0;
        snap = exp_lat;
        ss_n = 1'b0;
        idle(HALF);
        if (late_en) begin
            ovt_flags = late;
            exp_lat   = exp_lat | late;
        end
        for (int b = nbits - 1; b >= 0; b--) begin
            sdi = din[b];
            idle(HALF);
            dout = {dout[30:0], sdo};
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        ss_n = 1'b1;
        idle(HALF + 3);
        exp_lat = ovt_flags;
        if (nbits % 8 != 0 || (mode16 && !code_ok(din[15:0]))) begin
            exp_err = 1'b1;
        end else begin
            exp_err  = 1'b0;
            exp_chan = mode16 ? din[15:8] : din[7:0];
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [15:0] cmd;
        logic pe;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        chk("R1 chan_en", chan_en, 0);
        chk("R1 frame_err", frame_err, 0);
        chk("R1 sdo_oe", sdo_oe, 0);

        // 8-bit sweep over all channel patterns with changing flags.
        mode16 = 1'b0;
        for (int i = 0; i < 256; i++) begin
            set_flags(8'((i * 37) ^ 8'h5a));
            xfer(8, i, 1'b0, 8'h00, r);
            chk("R3 chan_en", chan_en, exp_chan);
            chk("R3 R9 reply8", r[7:0], snap);
            chk("R7 frame_err", frame_err, exp_err);
        end
        chk("R2 oe deselected", sdo_oe, 0);

        // Late event is held for the following transfer.
        set_flags(8'h00);
        xfer(8, 32'h3c, 1'b0, 8'h00, r);
        set_flags(8'h00);
        xfer(8, 32'h3c, 1'b1, 8'h81, r);
        chk("R9 frozen snapshot", r[7:0], 8'h00);
        set_flags(8'h00);
        xfer(8, 32'h3c, 1'b0, 8'h00, r);
        chk("R9 late event reported", r[7:0], 8'h81);
        xfer(8, 32'h3c, 1'b0, 8'h00, r);
        chk("R9 cleared after report", r[7:0], 8'h00);

        // Wrong lengths in 8-bit mode.
        xfer(7, 32'h55, 1'b0, 8'h00, r);
        chk("R6 len7 err", frame_err, 1);
        chk("R6 len7 chan held", chan_en, 8'h3c);
        xfer(9, 32'h1ff, 1'b0, 8'h00, r);
        chk("R6 len9 err", frame_err, 1);
        chk("R6 len9 chan held", chan_en, 8'h3c);

        // Chained 8-bit transfer: first byte comes back after the reply.
        xfer(16, 32'ha5c3, 1'b0, 8'h00, r);
        chk("R10 chain8 chan", chan_en, 8'hc3);
        chk("R10 chain8 echo", r[7:0], 8'ha5);
        chk("R10 chain8 reply", r[15:8], 8'h00);

        // 16-bit sweep with status bits varying.
        mode16 = 1'b1;
        for (int i = 0; i < 256; i++) begin
            set_flags(8'((i * 91) ^ 8'hc6));
            fb_ok = i[0]; temp_warn = i[1]; pwr_good = i[2];
            pe = exp_err;
            xfer(16, mk_cmd(8'(i), 4'(i >> 3)), 1'b0, 8'h00, r);
            chk("R4 chan_en", chan_en, exp_chan);
            chk("R5 R8 reply16", r[15:0], mk_reply(snap, fb_ok, temp_warn, pe, pwr_good));
            chk("R7 frame_err", frame_err, exp_err);
        end

        // Corrupt each parity bit in turn.
        for (int k = 0; k < 4; k++) begin
            cmd = mk_cmd(8'h5a, 4'h0) ^ 16'(1 << k);
            xfer(16, cmd, 1'b0, 8'h00, r);
            chk("R7 parity err", frame_err, 1);
            chk("R7 chan held", chan_en, 8'hff);
        end
        set_flags(8'h00);
        pe = exp_err;
        xfer(16, mk_cmd(8'h96, 4'hf), 1'b0, 8'h00, r);
        chk("R8 pe bit set", r[5], 1);
        chk("R4 dont care accepted", chan_en, 8'h96);
        chk("R7 err cleared", frame_err, 0);

        // Wrong length in 16-bit mode.
        xfer(15, mk_cmd(8'h0f, 4'h0), 1'b0, 8'h00, r);
        chk("R6 len15 err", frame_err, 1);
        chk("R6 len15 chan held", chan_en, 8'h96);

        // Chained 16-bit transfer.
        set_flags(8'h21);
        fb_ok = 1'b1; temp_warn = 1'b0; pwr_good = 1'b1;
        pe = exp_err;
        xfer(32, {16'hbeef, mk_cmd(8'h71, 4'h0)}, 1'b0, 8'h00, r);
        chk("R10 chain16 chan", chan_en, 8'h71);
        chk("R10 chain16 echo", r[15:0], 16'hbeef);
        chk("R10 chain16 reply", r[31:16], mk_reply(snap, 1'b1, 1'b0, pe, 1'b1));
        chk("R2 oe after chain", sdo_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule